// File: doc/BRIEF.md
# Redundant-Digit Pipeline Code Aligner

This block is the digital back end of a pipelined analog-to-digital converter. It receives, on every clock, a 2-bit decision from each of six redundant 1.5-bit stages and a 3-line thermometer word from the final 2-bit flash stage. Each sample reaches the stages one clock apart, so the block holds every stage's code in a shift chain until all codes of the same sample line up. It then decodes the thermometer word to binary and adds the aligned codes with a one-bit overlap into an 8-bit corrected result. A stage that picked the middle code where the top code was right is therefore fixed by a carry from the later stages.

A small fill sequencer raises the valid flag once the alignment chains hold a complete sample. It has two states. `FILL_ST` is entered at reset and counts edges. The transition `fill_done` moves it to `RUN_ST` on the seventh edge after reset. `RUN_ST` only leaves on reset. A second two-state machine watches the raw inputs. It starts in `ERR_CLEAR` and takes the transition `fault_seen` to `ERR_HELD` on any illegal code. `ERR_HELD` only leaves on reset.

Top module: `redundant_code_aligner`

## Requirements
- R1: Each stage code is a 2-bit field: stage k (k = 1..6) occupies bits [2k-1:2k-2] of `stage_code_i`. 00 = value 0, 01 = value 1, 10 = value 2. The value 11 is illegal and, if it appears, is summed as 3.
- R2: The flash word `flash_therm_i` has 3 lines with bit 0 as the lowest threshold. The monotonic patterns 000, 001, 011 and 111 decode to 0, 1, 2 and 3. Any pattern is decoded as the number of lines that are set.
- R3: Stage k's code is delayed by 7-k clocks and the flash word is not delayed. A sample whose stage-1 code is driven in cycle c has its result on `result_o` after the clock edge that ends cycle c+6, provided each later stage's code arrives one cycle after the previous one.
- R4: The result is the sum of all stage values, with stage k weighted by 2^(7-k), plus the decoded flash value with weight 1.
- R5: When the sum exceeds 255, `result_o` saturates at 255.
- R6: All-zero codes give 0. All stages at 10 with flash 111 give 255.
- R7: `valid_o` is low from reset until the seventh clock edge after reset, and high from then on. `result_o` stays 0 while `valid_o` is low.
- R8: `code_err_o` rises after the edge on which any stage input shows 11 or the flash word is non-monotonic. It then stays high until reset.
- R9: During reset `result_o`, `valid_o` and `code_err_o` are all 0.
- R10: A stage that reports 01 while the next stage reports 10 yields the same result as that stage reporting 10 and the next stage reporting 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| stage_code_i | input | 12 | Raw 2-bit codes of stages 1..6, stage 1 in the low bits |
| flash_therm_i | input | 3 | Thermometer word from the final flash stage |
| result_o | output | 8 | Corrected, saturated conversion result |
| valid_o | output | 1 | Result carries a real sample |
| code_err_o | output | 1 | Sticky illegal-code flag |

## Verification
The bench builds the block with its defaults: six redundant stages and a 2-bit flash stage. With these values the full 255 code and the exact seven-edge fill are reachable with legal inputs, and saturation is reachable only through illegal 11 codes. The bench streams one new sample every cycle, skewed across the stages as a real converter would deliver them. This gives one-hot patterns that expose any wrong delay depth, and carry-correction pairs that must produce equal results. A mid-run reset checks that both state machines return to their first state.

// File: rtl/rca_pkg.sv
package rca_pkg;

    localparam int STAGE_CODE_W = 2;

    typedef enum logic {
        FILL_ST,
        RUN_ST
    } fill_state_e;

    typedef enum logic {
        ERR_CLEAR,
        ERR_HELD
    } err_state_e;

    function automatic logic stage_code_bad(input logic [STAGE_CODE_W-1:0] code);
        return code == 2'b11;
    endfunction

endpackage

// File: rtl/code_delay.sv
module code_delay #(
    parameter int W     = 2,
    parameter int DEPTH = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    logic [W-1:0] taps [DEPTH];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                taps[i] <= '0;
            end
        end else begin
            taps[0] <= din;
            for (int i = 1; i < DEPTH; i++) begin
                taps[i] <= taps[i-1];
            end
        end
    end

    assign dout = taps[DEPTH-1];

endmodule

// File: rtl/therm_decoder.sv
module therm_decoder #(
    parameter int LINES = 3,
    parameter int BIN_W = 2
) (
    input  logic [LINES-1:0] therm_i,
    output logic [BIN_W-1:0] bin_o,
    output logic             bubble_o
);

    // A higher line set while the line below it is clear breaks monotonicity.
    assign bubble_o = |(therm_i[LINES-1:1] & ~therm_i[LINES-2:0]);

    always_comb begin
        bin_o = '0;
        for (int i = 0; i < LINES; i++) begin
            bin_o = bin_o + BIN_W'(therm_i[i]);
        end
    end

endmodule

// File: rtl/fill_sequencer.sv
module fill_sequencer
    import rca_pkg::*;
#(
    parameter int FILL_CYC = 7
) (
    input  logic clk,
    input  logic rst_n,
    output logic load_o,
    output logic valid_o
);

    localparam int CW = $clog2(FILL_CYC + 1);
    localparam logic [CW-1:0] LAST_FILL = CW'(FILL_CYC - 1);

    fill_state_e state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= FILL_ST;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // next state: fill_done moves FILL_ST to RUN_ST
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            FILL_ST: begin
                cnt_d = cnt_q + 1'b1;
                if (cnt_q == LAST_FILL) begin
                    state_d = RUN_ST;
                end
            end
            RUN_ST: begin
                state_d = RUN_ST;
            end
        endcase
    end

    // outputs
    always_comb begin
        load_o  = 1'b0;
        valid_o = 1'b0;
        unique case (state_q)
            FILL_ST: load_o = (cnt_q == LAST_FILL);
            RUN_ST: begin
                load_o  = 1'b1;
                valid_o = 1'b1;
            end
        endcase
    end

    assert_valid_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> valid_o);

    assert_valid_after_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(valid_o) |-> $past(load_o));

endmodule

// File: rtl/error_monitor.sv
module error_monitor
    import rca_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic bad_i,
    output logic err_o
);

    err_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ERR_CLEAR;
        end else begin
            state_q <= state_d;
        end
    end

    // fault_seen moves ERR_CLEAR to ERR_HELD
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ERR_CLEAR: if (bad_i) state_d = ERR_HELD;
            ERR_HELD:  state_d = ERR_HELD;
        endcase
    end

    always_comb begin
        unique case (state_q)
            ERR_CLEAR: err_o = 1'b0;
            ERR_HELD:  err_o = 1'b1;
        endcase
    end

    assert_err_raise_R8: assert property (@(posedge clk) disable iff (!rst_n)
        bad_i |=> err_o);

    assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> err_o);

endmodule

// File: rtl/redundant_code_aligner.sv
module redundant_code_aligner
    import rca_pkg::*;
#(
    parameter int NUM_STAGES = 6,
    parameter int FLASH_BITS = 2
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [NUM_STAGES*STAGE_CODE_W-1:0] stage_code_i,
    input  logic [(1<<FLASH_BITS)-2:0]       flash_therm_i,
    output logic [NUM_STAGES+FLASH_BITS-1:0] result_o,
    output logic                             valid_o,
    output logic                             code_err_o
);

    localparam int THERM_LINES = (1 << FLASH_BITS) - 1;
    localparam int OUT_W       = NUM_STAGES + FLASH_BITS;
    localparam int SUM_W       = OUT_W + 2;
    localparam int FILL_CYC    = NUM_STAGES + 1;
    localparam logic [OUT_W-1:0] MAX_OUT = '1;

    logic [STAGE_CODE_W-1:0] aligned [NUM_STAGES];
    logic [NUM_STAGES-1:0]   code_bad;
    logic [FLASH_BITS-1:0]   flash_bin;
    logic                    therm_bubble;
    logic [SUM_W-1:0]        acc;
    logic [OUT_W-1:0]        sat;
    logic                    load;
    logic [OUT_W-1:0]        result_q;

    // Stage i+1 waits NUM_STAGES-i cycles so that the earliest stage waits longest.
    for (genvar i = 0; i < NUM_STAGES; i++) begin : g_stage
        code_delay #(
            .W    (STAGE_CODE_W),
            .DEPTH(NUM_STAGES - i)
        ) i_delay (
            .clk  (clk),
            .rst_n(rst_n),
            .din  (stage_code_i[i*STAGE_CODE_W +: STAGE_CODE_W]),
            .dout (aligned[i])
        );
        assign code_bad[i] = stage_code_bad(stage_code_i[i*STAGE_CODE_W +: STAGE_CODE_W]);
    end

    therm_decoder #(
        .LINES(THERM_LINES),
        .BIN_W(FLASH_BITS)
    ) i_therm (
        .therm_i (flash_therm_i),
        .bin_o   (flash_bin),
        .bubble_o(therm_bubble)
    );

    // Overlapped addition: each stage's LSB lands on the next stage's MSB.
    always_comb begin
        acc = SUM_W'(flash_bin);
        for (int i = 0; i < NUM_STAGES; i++) begin
            acc = acc + (SUM_W'(aligned[i]) << (NUM_STAGES + FLASH_BITS - 2 - i));
        end
    end

    always_comb begin
        if (acc > SUM_W'(MAX_OUT)) begin
            sat = MAX_OUT;
        end else begin
            sat = acc[OUT_W-1:0];
        end
    end

    fill_sequencer #(
        .FILL_CYC(FILL_CYC)
    ) i_fill (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_o (load),
        .valid_o(valid_o)
    );

    error_monitor i_err (
        .clk  (clk),
        .rst_n(rst_n),
        .bad_i((|code_bad) | therm_bubble),
        .err_o(code_err_o)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_q <= '0;
        end else if (load) begin
            result_q <= sat;
        end
    end

    assign result_o = result_q;

    assert_idle_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> (result_o == '0));

    assert_stage_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (stage_code_i[1:0] == 2'b11) |=> code_err_o);

endmodule

// File: tb/test_redundant_code_aligner.sv
module test_redundant_code_aligner;

    localparam int PERIOD = 10;
    localparam int MAXS   = 256;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] stage_code = '0;
    logic [2:0]  flash_therm = '0;
    logic [7:0]  result;
    logic        valid;
    logic        code_err;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;
    int nsamp   = 0;
    bit exp_err = 1'b0;

    logic [1:0] sc_mem [0:MAXS-1][0:5];
    logic [2:0] th_mem [0:MAXS-1];
    string      tag_mem [0:MAXS-1];

    always #(PERIOD/2) clk = ~clk;

    redundant_code_aligner i_redundant_code_aligner (
        .clk          (clk),
        .rst_n        (rst_n),
        .stage_code_i (stage_code),
        .flash_therm_i(flash_therm),
        .result_o     (result),
        .valid_o      (valid),
        .code_err_o   (code_err)
    );

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
        end
    endtask

    function automatic int expect_of(input int s);
        int sum = 0;
        for (int k = 0; k < 6; k++) begin
            sum += int'(sc_mem[s][k]) << (6 - k);
        end
        sum += $countones(th_mem[s]);
        if (sum > 255) sum = 255;
        return sum;
    endfunction

    // One cycle: drive the skewed codes of the in-flight samples, then check.
    task automatic step();
        logic [2:0] th;
        for (int k = 0; k < 6; k++) begin
            int idx = cyc - k;
            stage_code[2*k +: 2] = (idx >= 0) ? sc_mem[idx][k] : 2'b00;
            if (idx >= 0 && sc_mem[idx][k] == 2'b11) exp_err = 1'b1;
        end
        th = (cyc >= 6) ? th_mem[cyc-6] : 3'b000;
        flash_therm = th;
        if ((th[1] && !th[0]) || (th[2] && !th[1])) exp_err = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check(valid == (cyc >= 6), "R7 valid", int'(valid), int'(cyc >= 6));
        if (cyc >= 6) begin
            check(int'(result) == expect_of(cyc-6), tag_mem[cyc-6], int'(result), expect_of(cyc-6));
        end else begin
            check(result == 8'd0, "R7 idle result", int'(result), 0);
        end
        check(code_err == exp_err, "R8 error flag", int'(code_err), int'(exp_err));
        cyc++;
    endtask

    task automatic push(input string tag, input logic [11:0] codes, input logic [2:0] th);
        for (int k = 0; k < 6; k++) sc_mem[nsamp][k] = codes[2*k +: 2];
        th_mem[nsamp]  = th;
        tag_mem[nsamp] = tag;
        nsamp++;
        step();
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        stage_code = '0;
        flash_therm = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(result == 8'd0, "R9 reset result", int'(result), 0);
        check(valid == 1'b0, "R9 reset valid", int'(valid), 0);
        check(code_err == 1'b0, "R9 reset error", int'(code_err), 0);
        rst_n = 1'b1;
        cyc = 0;
        nsamp = 0;
        exp_err = 1'b0;
    endtask

    task automatic t_flush();
        for (int i = 0; i < 7; i++) push("R3 flush", 12'h000, 3'b000);
    endtask

    task automatic t_corners();
        push("R6 zero", 12'h000, 3'b000);
        push("R6 full", {6{2'b10}}, 3'b111);
        push("R4 mid", {6{2'b01}}, 3'b011);
        push("R1 R2 flash one", 12'h000, 3'b001);
    endtask

    task automatic t_onehot();
        for (int j = 0; j < 6; j++) begin
            logic [11:0] c = '0;
            c[2*j +: 2] = 2'b10;
            push("R3 one-hot stage", c, 3'b000);
        end
        push("R3 one-hot mid", 12'b00_00_00_01_00_00, 3'b000);
    endtask

    task automatic t_carry();
        // stage1=10 vs stage1=01 with stage2=10: both 128
        push("R10 direct", 12'b00_00_00_00_00_10, 3'b000);
        push("R10 corrected", 12'b00_00_00_00_10_01, 3'b000);
        // deeper: stage4=10 vs stage4=01,stage5=10
        push("R10 direct deep", 12'b00_00_10_00_00_01, 3'b011);
        push("R10 corrected deep", 12'b00_10_01_00_00_01, 3'b011);
        push("R4 mixed", 12'b01_10_00_01_10_01, 3'b001);
    endtask

    task automatic t_errors();
        t_reset();
        push("R2 legal", 12'b00_00_00_00_00_01, 3'b111);
        push("R8 bubble", 12'h000, 3'b101);
        t_flush();
        t_reset();
        push("R5 saturate", {6{2'b11}}, 3'b111);
        push("R5 saturate mixed", 12'b10_10_10_10_10_11, 3'b111);
        t_flush();
    endtask

    initial begin
        #(PERIOD * 100000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests + 1, n_fail);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_corners();
        t_onehot();
        t_carry();
        t_flush();
        t_errors();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule